// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block steps an 8-bit analog-to-digital conversion one bit per clock against an outside comparator. A start pulse, taken while the block is idle, loads a trial code with the top bit clear and all lower bits set. The trial code goes to an outside DAC. On each of the next eight clocks the block samples a one-bit comparator result. That result decides the bit under test, and the next lower bit is cleared so that it becomes the next trial. The busy output is high for exactly the eight clocks of the conversion. When busy falls, the host reads the result: the final register contents with the top bit inverted, which is a two's complement code at 20 mV per step over -2.56 V to +2.54 V.

A timer-only mode, chosen with the start pulse, gives the same eight-clock busy window for analog output cycles. In this mode the comparator and the register are not used. The controller is a three-state machine. ST_IDLE waits for start. It goes to ST_CONV when start is high and timer_only is low, and to ST_TIME when start and timer_only are both high. ST_CONV and ST_TIME count a bit index down from 7. On the clock where the index is 0, both return to ST_IDLE. Any other clock in those two states stays put and decrements the index.

Top module: `sar_sequencer`

## Requirements
- R1: When start is high at a rising edge while busy is low, busy is high from the next cycle on.
- R2: A conversion start loads the trial code 8'h7F: bit 7 at 0 and bits 6..0 at 1.
- R3: At each conversion clock, the bit under test becomes 1 if cmp_above is high and stays 0 if it is low. cmp_above high means the input is above the present trial code.
- R4: Bits are decided in order from bit 7 down to bit 0, one per clock. In the clock that decides bit k, bit k-1 is cleared to 0, and higher decided bits do not change.
- R5: busy stays high for exactly 8 cycles after the start edge, then falls.
- R6: result equals the register with bit 7 inverted. An input equal to register code 8'h80 gives 8'h00 (zero), 8'h00 gives 8'h80 (most negative), and 8'hFF gives 8'h7F (full-scale positive).
- R7: After a conversion, trial and result hold their values, whatever cmp_above does, until the next start.
- R8: A start pulse while busy is high is ignored: the conversion ends at its original time with its correct result.
- R9: A synchronous active-high rst clears the register to 8'h00 (result 8'h80) and drops busy in the next cycle, including during a conversion.
- R10: A start with timer_only high gives the same 8-cycle busy window, ignores cmp_above, and leaves trial and result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| timer_only | input | 1 | Sampled with start: 1 selects the busy window only |
| cmp_above | input | 1 | Comparator: 1 when the input is above the trial code |
| trial | output | 8 | Trial code to the DAC (the register) |
| busy | output | 1 | High during the 8-cycle window |
| result | output | 8 | Two's complement result (register with bit 7 inverted) |

## Verification
The assertions run on every cycle. They check that a start from idle raises busy, that the last index drops busy, and that a start during a window neither stops nor restarts the countdown. They also check the seed loaded by a start, that a decided MSB stays fixed during later trials, and that the register does not move outside a conversion. Only the bench scenarios can show that the bit sequence reaches the correct code for a given input, with the comparator modelled from the trial code. The same holds for the two's complement mapping at zero and at both full-scale ends, and for the timer-only mode leaving the earlier result in place.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_TIME = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
module sar_ctrl #(
    parameter int WIDTH = 8,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          timer_only,
    output logic          busy,
    output logic          load,
    output logic          decide,
    output logic [IW-1:0] idx
);
    import sar_pkg::*;

    localparam logic [IW-1:0] LAST = IW'(WIDTH - 1);

    sar_state_e    state, state_nx;
    logic [IW-1:0] idx_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= LAST;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_IDLE: begin
                idx_nx = LAST;
                if (start) state_nx = timer_only ? ST_TIME : ST_CONV;
            end
            ST_CONV, ST_TIME: begin
                if (idx == '0) begin
                    state_nx = ST_IDLE;
                    idx_nx   = LAST;
                end else begin
                    idx_nx = idx - IW'(1);
                end
            end
            default: begin
                state_nx = ST_IDLE;
                idx_nx   = LAST;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy   = 1'b0;
        load   = 1'b0;
        decide = 1'b0;
        unique case (state)
            ST_IDLE: load = start && !timer_only;
            ST_CONV: begin
                busy   = 1'b1;
                decide = 1'b1;
            end
            ST_TIME: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> busy);

    p_window_end_r5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && idx == '0) |=> !busy);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && idx != '0 && start) |=> (busy && idx == $past(idx) - IW'(1)));
endmodule

// File: rtl/sar_bits.sv
`timescale 1ns/1ps
module sar_bits #(
    parameter int WIDTH = 8,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             decide,
    input  logic [IW-1:0]    idx,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] sar_q
);
    localparam logic [WIDTH-1:0] SEED = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [IW-1:0]    LAST = IW'(WIDTH - 1);

    logic [WIDTH-1:0] sar_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam logic [IW-1:0] MY  = IW'(i);
        localparam logic [IW-1:0] UP1 = IW'((i + 1) % WIDTH);
        always_comb begin
            if (load)
                sar_d[i] = SEED[i];
            else if (decide && idx == MY)
                sar_d[i] = cmp_above;
            else if (decide && i < WIDTH - 1 && idx == UP1)
                sar_d[i] = 1'b0;
            else
                sar_d[i] = sar_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sar_q <= '0;
        else     sar_q <= sar_d;
    end

    p_seed_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (sar_q == SEED));

    p_msb_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (decide && idx != LAST) |=> $stable(sar_q[WIDTH-1]));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !decide) |=> $stable(sar_q));
endmodule

// File: rtl/sar_fmt.sv
`timescale 1ns/1ps
module sar_fmt #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sar_q,
    output logic [WIDTH-1:0] result
);
    // Offset binary to two's complement: invert the sign bit only
    assign result = {~sar_q[WIDTH-1], sar_q[WIDTH-2:0]};
endmodule

// File: rtl/sar_sequencer.sv
`timescale 1ns/1ps
module sar_sequencer #(
    parameter int WIDTH = 8,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             timer_only,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] trial,
    output logic             busy,
    output logic [WIDTH-1:0] result
);
    logic          load, decide;
    logic [IW-1:0] idx;

    sar_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .timer_only(timer_only),
        .busy(busy), .load(load), .decide(decide), .idx(idx)
    );

    sar_bits #(.WIDTH(WIDTH)) u_bits (
        .clk(clk), .rst(rst), .load(load), .decide(decide), .idx(idx),
        .cmp_above(cmp_above), .sar_q(trial)
    );

    sar_fmt #(.WIDTH(WIDTH)) u_fmt (
        .sar_q(trial), .result(result)
    );
endmodule

// File: tb/test_sar_sequencer.sv
`timescale 1ns/1ps
module test_sar_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       timer_only = 1'b0;
    logic [7:0] vin = 8'h00;
    logic       cmp_above;
    logic [7:0] trial, result;
    logic       busy;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] last_res;

    always #2 clk = ~clk;

    // Comparator / DAC model: high when the input is above the trial code
    assign cmp_above = (vin > trial);

    sar_sequencer i_sar_sequencer (
        .clk(clk), .rst(rst), .start(start), .timer_only(timer_only),
        .cmp_above(cmp_above), .trial(trial), .busy(busy), .result(result)
    );

    // {input register code, expected two's complement result}
    localparam logic [15:0] VEC [0:7] = '{
        16'h80_00, 16'h00_80, 16'hFF_7F, 16'h7F_FF,
        16'h81_01, 16'hA5_25, 16'h01_81, 16'h5A_DA
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge after the window
    task automatic convert(input logic [7:0] v, input logic tmr,
                           input logic [7:0] exp_res, input logic poke);
        vin = v;
        timer_only = tmr;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (c > 0) @(negedge clk);
            chk(tmr ? "R10 busy window" : "R5 busy window", {7'd0, busy}, 8'd1);
            if (c == 0 && !tmr) chk("R2 seed", trial, 8'h7F);
            if (c == 1 && !tmr) begin
                chk("R4 next bit cleared", {1'b0, trial[6:0]}, 8'h3F);
                chk("R3 msb decision", {7'd0, trial[7]}, {7'd0, (v >= 8'h80)});
            end
            if (c == 0 && tmr) chk("R10 trial untouched", result, exp_res);
            start = (poke && c == 3);
        end
        start = 1'b0;
        @(negedge clk);
        chk(poke ? "R8 end on time" : "R5 busy falls", {7'd0, busy}, 8'd0);
        chk(tmr ? "R10 result kept" : (poke ? "R8 result" : "R6 result"), result, exp_res);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset busy", {7'd0, busy}, 8'd0);
        chk("R9 reset trial", trial, 8'h00);
        chk("R9 reset result", result, 8'h80);

        // Table walk
        for (int k = 0; k < 8; k++) begin
            convert(VEC[k][15:8], 1'b0, VEC[k][7:0], 1'b0);
            last_res = VEC[k][7:0];
        end

        // R1: a start from idle raises busy on the next cycle
        vin = 8'h33;
        start = 1'b1;
        @(posedge clk);
        #1 chk("R1 busy after start", {7'd0, busy}, 8'd1);
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R1 conversion result", result, 8'hB3);
        last_res = 8'hB3;

        // R7: hold while the comparator moves
        vin = 8'hCC;
        repeat (6) @(negedge clk);
        chk("R7 result held", result, last_res);
        chk("R7 trial held", trial, 8'h33);

        // R8: start during a window
        convert(8'hC4, 1'b0, 8'h44, 1'b1);
        last_res = 8'h44;

        // R10: timer-only window leaves the earlier result
        convert(8'h10, 1'b1, last_res, 1'b0);
        chk("R10 trial after timer", trial, 8'hC4);

        // R9: reset in the middle of a conversion
        vin = 8'h99;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid reset busy", {7'd0, busy}, 8'd0);
        chk("R9 mid reset result", result, 8'h80);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 stays idle", {7'd0, busy}, 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule